// File: doc/BRIEF.md
# Display pipe shutdown sequencer

This block turns a running display pipe off in a safe, fixed order. Software keeps three request lines (memory self-refresh, plane, pipe) high while the pipe runs, and the block passes them through to its enable outputs. On a start command it forces the enables low one at a time. First it drops self-refresh. Next it drops the plane. It then waits for a vblank, drops the pipe, and finally waits for the pipe to report that it is off.

The ordering matters because the plane control register takes its new value only at vblank, and it cannot take it while memory self-refresh is active. Self-refresh is sampled at frame start. The self-refresh off step must therefore come before the plane off step. A real vblank must also fall between the plane off step and the pipe off step, so that the plane is truly off before the pipe stops. Each wait has a cycle limit. When the limit runs out, the sequence aborts with an error flag.

A forced-low enable stays low until software drops the matching request. After that, the output follows the request again.

Top module: `pipe_off_seq`

## Requirements
- R1: After reset, done_o and err_o are 0 and each enable output equals its request input.
- R2: While idle, each enable output (sr_en_o, plane_en_o, pipe_en_o) follows its request input combinationally.
- R3: The clock edge that samples start_i high in idle makes sr_en_o 0, while plane_en_o and pipe_en_o keep their values.
- R4: plane_en_o goes to 0 on the next clock edge after sr_en_o goes to 0.
- R5: pipe_en_o stays 1 until a vblank_i pulse is sampled after the plane step. A vblank_i that is sampled on the plane step edge, or earlier, does not count.
- R6: pipe_en_o goes to 0 on the edge that samples vblank_i high in the vblank wait.
- R7: done_o is high for exactly one cycle, beginning at the edge that samples pipe_off_i high in the pipe-off wait, and the block is idle afterwards.
- R8: start_i is ignored while a sequence is running.
- R9: If no vblank_i is sampled for TMO_CYC edges in the vblank wait, err_o goes to 1, the block returns to idle, pipe_en_o stays 1 and done_o stays 0.
- R10: If no pipe_off_i is sampled for TMO_CYC edges in the pipe-off wait, err_o goes to 1, the block returns to idle and done_o stays 0.
- R11: err_o holds its value until the next start that is accepted, and that start clears it on the same edge.
- R12: An enable output that the sequence forced low stays 0 while its request is high. Once the request has been sampled low, the output follows the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin shutdown (sampled in idle only) |
| vblank_i | input | 1 | Vblank-start event |
| pipe_off_i | input | 1 | Pipe reports it has stopped |
| sr_req_i | input | 1 | Software request for memory self-refresh |
| plane_req_i | input | 1 | Software request for plane enable |
| pipe_req_i | input | 1 | Software request for pipe enable |
| sr_en_o | output | 1 | Memory self-refresh enable |
| plane_en_o | output | 1 | Plane enable |
| pipe_en_o | output | 1 | Pipe enable |
| done_o | output | 1 | One-cycle pulse when shutdown completes |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The bench sends a vblank on the exact edge of the plane step. A design that counted that vblank would stop the pipe while the plane update was still pending. It gives the vblank and pipe-off events on the last allowed cycle of each wait and withholds them entirely, to pin down the timeout boundary. A counter off by one would abort a valid sequence or wait one cycle too long. It also sends start pulses during the pipe-off wait. A design that accepted those pulses would restart and never pulse done. Finally, it raises the requests again after shutdown, which catches a release latch that either never clears or clears too early.

// File: rtl/pso_pkg.sv
package pso_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLANE = 2'd1,
    ST_VBL   = 2'd2,
    ST_OFF   = 2'd3
  } pso_state_e;

  localparam int unsigned CTL_SR    = 0;
  localparam int unsigned CTL_PLANE = 1;
  localparam int unsigned CTL_PIPE  = 2;
  localparam int unsigned NUM_CTL   = 3;
endpackage

// File: rtl/pso_timer.sv
module pso_timer #(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/pso_gate.sv
module pso_gate #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] kill_set_i,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_ctl
    logic kill_q;
    // forced-off bit is held until software drops its request
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            kill_q <= 1'b0;
      else if (kill_set_i[g]) kill_q <= 1'b1;
      else if (!req_i[g])     kill_q <= 1'b0;
    end
    assign en_o[g] = req_i[g] & ~kill_q;
  end
endmodule

// File: rtl/pso_fsm.sv
module pso_fsm
  import pso_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               vblank_i,
  input  logic               pipe_off_i,
  input  logic               expired_i,
  output logic [NUM_CTL-1:0] kill_set_o,
  output logic               run_o,
  output logic               done_o,
  output logic               err_o
);
  pso_state_e state_q, state_d;
  logic abort, fin;

  always_comb begin
    state_d    = state_q;
    kill_set_o = '0;
    run_o      = 1'b0;
    abort      = 1'b0;
    fin        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d            = ST_PLANE;
        kill_set_o[CTL_SR] = 1'b1;
      end
      ST_PLANE: begin
        state_d               = ST_VBL;
        kill_set_o[CTL_PLANE] = 1'b1;
      end
      ST_VBL: begin
        if (vblank_i) begin
          state_d              = ST_OFF;
          kill_set_o[CTL_PIPE] = 1'b1;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          abort   = 1'b1;
        end else begin
          run_o = 1'b1;
        end
      end
      ST_OFF: begin
        if (pipe_off_i) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          abort   = 1'b1;
        end else begin
          run_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
      if (abort)                              err_o <= 1'b1;
      else if (state_q == ST_IDLE && start_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pipe_off_seq.sv
module pipe_off_seq
  import pso_pkg::*;
#(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vblank_i,
  input  logic pipe_off_i,
  input  logic sr_req_i,
  input  logic plane_req_i,
  input  logic pipe_req_i,
  output logic sr_en_o,
  output logic plane_en_o,
  output logic pipe_en_o,
  output logic done_o,
  output logic err_o
);
  logic [NUM_CTL-1:0] kill_set, req, en;
  logic               run, expired;

  assign req[CTL_SR]    = sr_req_i;
  assign req[CTL_PLANE] = plane_req_i;
  assign req[CTL_PIPE]  = pipe_req_i;

  pso_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .vblank_i   (vblank_i),
    .pipe_off_i (pipe_off_i),
    .expired_i  (expired),
    .kill_set_o (kill_set),
    .run_o      (run),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  pso_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .expired_o (expired)
  );

  pso_gate #(.N(NUM_CTL)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .kill_set_i (kill_set),
    .en_o       (en)
  );

  assign sr_en_o    = en[CTL_SR];
  assign plane_en_o = en[CTL_PLANE];
  assign pipe_en_o  = en[CTL_PIPE];
endmodule

// File: rtl/pso_chk.sv
module pso_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic vblank_i,
  input logic pipe_off_i,
  input logic sr_req_i,
  input logic plane_req_i,
  input logic pipe_req_i,
  input logic sr_en_o,
  input logic plane_en_o,
  input logic pipe_en_o,
  input logic done_o,
  input logic err_o
);
  AST_SR_BEFORE_PLANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(plane_en_o) && plane_req_i) |-> !sr_en_o); // R4

  AST_PLANE_BEFORE_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pipe_en_o) && pipe_req_i) |-> !plane_en_o); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(pipe_off_i)); // R7

  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o); // R10
endmodule

bind pipe_off_seq pso_chk u_chk (.*);

// File: tb/sim_pipe_off_seq.sv
`timescale 1ns/1ps
module sim_pipe_off_seq;
  localparam int unsigned TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, vblank = 0, pipe_off = 0;
  logic [2:0] req = 3'b111;
  logic sr_en, plane_en, pipe_en, done, err;
  logic [2:0] killed = 3'b000;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pipe_off_seq #(.TMO_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vblank_i(vblank),
    .pipe_off_i(pipe_off), .sr_req_i(req[0]), .plane_req_i(req[1]),
    .pipe_req_i(req[2]), .sr_en_o(sr_en), .plane_en_o(plane_en),
    .pipe_en_o(pipe_en), .done_o(done), .err_o(err)
  );

  function automatic logic [2:0] exp_en(logic [2:0] r, logic [2:0] k);
    return r & ~k;
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      report();
      $finish;
    end
  end

  task automatic chk(string r, string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%b exp=%b", r, nm, act, exp);
    end
  endtask

  task automatic chk_en(string r);
    logic [2:0] e;
    e = exp_en(req, killed);
    chk(r, "sr_en", sr_en, e[0]);
    chk(r, "plane_en", plane_en, e[1]);
    chk(r, "pipe_en", pipe_en, e[2]);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // R12: hold while requests high, then release through a low request
  task automatic release_all();
    step();
    chk_en("R12");
    req = 3'b000;
    step();
    killed = 3'b000;
    req = 3'b111;
    #1;
    chk_en("R12");
  endtask

  task automatic run_seq(int vd, int od, bit inj, bit early);
    start = 1;
    step();
    start = 0;
    killed[0] = 1;
    chk_en("R3");
    if (early) vblank = 1;   // R5: vblank on the plane-step edge must not count
    step();
    vblank = 0;
    killed[1] = 1;
    chk_en("R4");
    for (int i = 0; i < vd; i++) begin
      step();
      chk_en("R5");
    end
    vblank = 1;
    step();
    vblank = 0;
    killed[2] = 1;
    chk_en("R6");
    chk("R6", "done", done, 1'b0);
    for (int i = 0; i < od; i++) begin
      if (inj && i == 0) start = 1;   // R8
      step();
      start = 0;
      chk("R8", "done", done, 1'b0);
    end
    pipe_off = 1;
    step();
    pipe_off = 0;
    chk("R7", "done", done, 1'b1);
    chk("R7", "err", err, 1'b0);
    step();
    chk("R7", "done_clear", done, 1'b0);
    release_all();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #5;
    chk("R1", "done_rst", done, 1'b0);
    chk("R1", "err_rst", err, 1'b0);
    chk_en("R1");
    rst_n = 1;
    step();
    chk_en("R1");

    for (int i = 0; i < 8; i++) begin
      req = 3'($urandom % 8);
      #1;
      chk_en("R2");
      step();
    end
    req = 3'b111;
    step();

    run_seq(0, 0, 0, 0);
    run_seq(TMO - 1, TMO - 1, 1, 1);
    run_seq(3, 2, 1, 1);

    // R9: vblank never arrives
    start = 1;
    step();
    start = 0;
    killed[0] = 1;
    step();
    killed[1] = 1;
    for (int i = 0; i < TMO - 1; i++) begin
      step();
      chk("R9", "err_early", err, 1'b0);
    end
    step();
    chk("R9", "err", err, 1'b1);
    chk("R9", "done", done, 1'b0);
    chk_en("R9");
    step();
    chk("R11", "err_hold", err, 1'b1);
    start = 1;
    step();
    start = 0;
    chk("R11", "err_clear", err, 1'b0);
    for (int i = 0; i < TMO + 1; i++) step();
    chk("R9", "err_again", err, 1'b1);
    release_all();

    // R10: pipe never reports off
    start = 1;
    step();
    start = 0;
    killed[0] = 1;
    step();
    killed[1] = 1;
    vblank = 1;
    step();
    vblank = 0;
    killed[2] = 1;
    for (int i = 0; i < TMO - 1; i++) begin
      step();
      chk("R10", "err_early", err, 1'b0);
    end
    step();
    chk("R10", "err", err, 1'b1);
    chk("R10", "done", done, 1'b0);
    release_all();

    for (int k = 0; k < 12; k++)
      run_seq(int'($urandom % TMO), int'($urandom % TMO),
              bit'($urandom % 2), bit'($urandom % 2));

    report();
    $finish;
  end
endmodule